// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and decides, command by command, whether a write-type operation may start. A serial front-end decodes the incoming opcodes. It presents one single-cycle strobe per decoded command together with the target byte address and the data byte for a status write. The block reads the hardware write-protect pin level directly.

For every cycle that carries a strobe, the block answers one cycle later with exactly one of two pulses: accept or reject. An accepted status write, page program, sector erase or bulk erase starts a self-timed busy period. The length of that period is set by a per-operation parameter and counted in clock cycles. The status byte can be read at all times, including during the busy period. The front-end uses the byte for status reads and for polling the busy bit. The serial shifting and the memory array itself are outside this block.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte is 00h and neither accept nor reject is asserted.
- R2: Status byte layout: bit 0 is the busy flag (WIP), bit 1 is the write-enable latch (WEL), bits 3:2 are the protect level {BP1,BP0}, and bit 7 is the register lock (SRWD). Bits 6:4 always read 0.
- R3: When idle, a write-enable strobe is accepted and sets WEL, and a write-disable strobe is accepted and clears WEL.
- R4: A status write, page program, sector erase or bulk erase strobe is rejected while WEL is 0. A rejected strobe changes no state.
- R5: An accepted status write, page program, sector erase or bulk erase sets WIP. WIP then stays set for exactly T_WRSR, T_PP, T_SE or T_BE cycles respectively. WIP and WEL both drop on the same edge.
- R6: An accepted status write captures wrsr_data bit 7 as SRWD and bits 3:2 as {BP1,BP0}. These values appear in the status byte on the edge where WIP drops.
- R7: When SRWD is 1 and wp_n is 0, a status write is rejected even with WEL set. With wp_n at 1 it is accepted.
- R8: A bulk erase is accepted only when the protect level is 00. Otherwise it is rejected.
- R9: A page program or sector erase is rejected when its address lies in the protected region. With level 01 the protected region is the top quarter (the two address MSBs are 11). With level 10 it is the upper half (the address MSB is 1). With level 11 it is the whole array.
- R10: While WIP is 1, every strobe is rejected, including write enable and write disable. The status byte shows WIP=1 throughout.
- R11: A cycle with more than one strobe high is rejected as a whole and changes no state.
- R12: Accept and reject are single-cycle pulses, registered on the edge that samples the strobe. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Bulk-erase strobe |
| addr | input | ADDR_W | Target byte address for program and erase |
| wrsr_data | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| op_accept | output | 1 | The command in the previous cycle was accepted |
| op_reject | output | 1 | The command in the previous cycle was rejected |
| status | output | 8 | Current status byte |

## Verification
Every strobe is sampled on one rising edge. Its accept or reject pulse, and its effect on WEL and WIP, show up right after that same edge. The bench therefore drives inputs on the falling edge and compares all outputs on the next falling edge against a cycle-stepped reference model. WIP drops T cycles after the accepting edge, and WEL and any staged protect bits change on that same edge. The model counts the busy period down once per edge, so the drop is checked in the exact cycle it is due.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_WIP  = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_BP1  = 3;
  localparam int SR_SRWD = 7;
  localparam int N_CMD   = 6;

  // strobe vector bit order
  localparam int C_WREN = 0;
  localparam int C_WRDI = 1;
  localparam int C_WRSR = 2;
  localparam int C_PP   = 3;
  localparam int C_SE   = 4;
  localparam int C_BE   = 5;

  function automatic logic [7:0] sr_pack(input logic wip, input logic wel,
                                         input logic [1:0] lvl, input logic lock);
    logic [7:0] v;
    v = 8'h00;
    v[SR_WIP]  = wip;
    v[SR_WEL]  = wel;
    v[SR_BP0]  = lvl[0];
    v[SR_BP1]  = lvl[1];
    v[SR_SRWD] = lock;
    return v;
  endfunction

  // top2 = two most significant address bits
  function automatic logic region_locked(input logic [1:0] top2, input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= dur;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/fsr_gate.sv
module fsr_gate
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5,
  parameter int T_WRSR = 5,
  parameter int T_PP   = 8,
  parameter int T_SE   = 12,
  parameter int T_BE   = 20
) (
  input  logic [N_CMD-1:0]  cmds,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wel,
  input  logic              busy,
  input  logic [1:0]        lvl,
  input  logic              lock,
  input  logic              wp_n,
  output logic              grant,
  output logic              deny,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              start,
  output logic [CNT_W-1:0]  dur,
  output logic              take_sr
);
  logic hw_lock, in_locked;
  int   n_cmd;

  assign hw_lock   = lock & ~wp_n;
  assign in_locked = region_locked(addr[ADDR_W-1 -: 2], lvl);
  assign n_cmd     = $countones(cmds);

  always_comb begin
    grant = 1'b0; deny = 1'b0; set_wel = 1'b0; clr_wel = 1'b0;
    start = 1'b0; dur = '0; take_sr = 1'b0;
    if (n_cmd != 0) begin
      if (n_cmd > 1 || busy) deny = 1'b1;
      else if (cmds[C_WREN]) begin grant = 1'b1; set_wel = 1'b1; end
      else if (cmds[C_WRDI]) begin grant = 1'b1; clr_wel = 1'b1; end
      else if (!wel) deny = 1'b1;
      else if (cmds[C_WRSR]) begin
        if (hw_lock) deny = 1'b1;
        else begin grant = 1'b1; start = 1'b1; take_sr = 1'b1; dur = CNT_W'(T_WRSR); end
      end else if (cmds[C_PP] || cmds[C_SE]) begin
        if (in_locked) deny = 1'b1;
        else begin
          grant = 1'b1; start = 1'b1;
          dur = cmds[C_PP] ? CNT_W'(T_PP) : CNT_W'(T_SE);
        end
      end else begin
        if (lvl != 2'b00) deny = 1'b1;
        else begin grant = 1'b1; start = 1'b1; dur = CNT_W'(T_BE); end
      end
    end
  end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int T_WRSR = 5,
  parameter int T_PP   = 8,
  parameter int T_SE   = 12,
  parameter int T_BE   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  output logic              op_accept,
  output logic              op_reject,
  output logic [7:0]        status
);
  localparam int T_M1  = (T_WRSR > T_PP) ? T_WRSR : T_PP;
  localparam int T_M2  = (T_SE > T_BE) ? T_SE : T_BE;
  localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [N_CMD-1:0] cmds;
  logic             wel, lock, pend_sr, pend_lock;
  logic [1:0]       lvl, pend_lvl;
  logic             grant, deny, set_wel, clr_wel, start, take_sr;
  logic [CNT_W-1:0] dur;
  logic             wip, wip_last;

  assign cmds = {cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren};

  fsr_gate #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .T_WRSR(T_WRSR), .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE)
  ) u_gate (
    .cmds(cmds), .addr(addr), .wel(wel), .busy(wip), .lvl(lvl), .lock(lock),
    .wp_n(wp_n), .grant(grant), .deny(deny), .set_wel(set_wel),
    .clr_wel(clr_wel), .start(start), .dur(dur), .take_sr(take_sr)
  );

  fsr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .dur(dur),
    .busy(wip), .last(wip_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_accept <= 1'b0; op_reject <= 1'b0;
      wel <= 1'b0; lock <= 1'b0; lvl <= 2'b00;
      pend_sr <= 1'b0; pend_lock <= 1'b0; pend_lvl <= 2'b00;
    end else begin
      op_accept <= grant;
      op_reject <= deny;
      if (set_wel) wel <= 1'b1;
      if (clr_wel) wel <= 1'b0;
      if (take_sr) begin
        pend_sr   <= 1'b1;
        pend_lock <= wrsr_data[SR_SRWD];
        pend_lvl  <= {wrsr_data[SR_BP1], wrsr_data[SR_BP0]};
      end
      if (wip_last) begin
        wel <= 1'b0;
        if (pend_sr) begin
          lock    <= pend_lock;
          lvl     <= pend_lvl;
          pend_sr <= 1'b0;
        end
      end
    end
  end

  assign status = sr_pack(wip, wel, lvl, lock);
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic       cmd_pp,
  input logic       cmd_se,
  input logic       cmd_be,
  input logic       wp_n,
  input logic       op_accept,
  input logic       op_reject,
  input logic [7:0] status,
  input logic       wip_last
);
  logic any_cmd;
  assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be;

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  p_wel_drops_with_wip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  p_wip_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !wip_last) |=> status[0]);

  p_hw_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status[7] && !wp_n) |=> op_reject);

  p_bulk_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_be && status[3:2] != 2'b00) |=> op_reject);

  p_busy_rejects_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && any_cmd) |=> op_reject);

  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_accept && op_reject));

  p_answer_needs_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> !(op_accept || op_reject));
endmodule

bind flash_sr_guard fsr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .cmd_wrsr(cmd_wrsr), .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
  .wp_n(wp_n), .op_accept(op_accept), .op_reject(op_reject),
  .status(status), .wip_last(wip_last)
);

// File: tb/flash_sr_guard_tb_top.sv
module flash_sr_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int T_WRSR = 5, T_PP = 8, T_SE = 12, T_BE = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrsr_data = '0;
  logic wp_n = 1'b1;
  logic op_accept, op_reject;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit m_wel = 0, m_lock = 0, m_pend = 0, m_plock = 0;
  logic [1:0] m_lvl = 0, m_plvl = 0;
  int m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sr_guard #(.ADDR_W(ADDR_W), .T_WRSR(T_WRSR), .T_PP(T_PP),
                   .T_SE(T_SE), .T_BE(T_BE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
    .addr(addr), .wrsr_data(wrsr_data), .wp_n(wp_n),
    .op_accept(op_accept), .op_reject(op_reject), .status(status)
  );

  function automatic bit addr_guarded(input logic [ADDR_W-1:0] a, input logic [1:0] lv);
    int ai;
    ai = int'(a);
    if (lv == 2'd0) return 0;
    if (lv == 2'd1) return ai >= 3 * (1 << (ADDR_W - 2));
    if (lv == 2'd2) return ai >= (1 << (ADDR_W - 1));
    return 1;
  endfunction

  function automatic logic [7:0] model_status();
    logic [7:0] s;
    s = 8'h00;
    s[0] = (m_left != 0);
    s[1] = m_wel;
    s[3:2] = m_lvl;
    s[7] = m_lock;
    return s;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", rq, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // c bit order: 0 wren, 1 wrdi, 2 wrsr, 3 pp, 4 se, 5 be
  task automatic cyc(input logic [5:0] c, input logic [ADDR_W-1:0] a,
                     input logic [7:0] d, input logic wp);
    bit e_acc, e_rej, go, setw, clrw, sr;
    int dlen;
    string rq;
    e_acc = 0; e_rej = 0; go = 0; setw = 0; clrw = 0; sr = 0; dlen = 0; rq = "R12";
    {cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren} = c;
    addr = a; wrsr_data = d; wp_n = wp;
    if ($countones(c) > 1) begin e_rej = 1; rq = "R11"; end
    else if (c != 0) begin
      if (m_left != 0) begin e_rej = 1; rq = "R10"; end
      else if (c[0]) begin e_acc = 1; setw = 1; rq = "R3"; end
      else if (c[1]) begin e_acc = 1; clrw = 1; rq = "R3"; end
      else if (!m_wel) begin e_rej = 1; rq = "R4"; end
      else if (c[2]) begin
        rq = "R7";
        if (m_lock && !wp) e_rej = 1;
        else begin e_acc = 1; go = 1; dlen = T_WRSR; sr = 1; end
      end else if (c[3] || c[4]) begin
        rq = "R9";
        if (addr_guarded(a, m_lvl)) e_rej = 1;
        else begin e_acc = 1; go = 1; dlen = c[3] ? T_PP : T_SE; end
      end else begin
        rq = "R8";
        if (m_lvl != 0) e_rej = 1;
        else begin e_acc = 1; go = 1; dlen = T_BE; end
      end
    end
    @(posedge clk);
    if (m_left != 0) begin
      m_left--;
      if (m_left == 0) begin
        m_wel = 0;
        if (m_pend) begin m_lock = m_plock; m_lvl = m_plvl; m_pend = 0; end
      end
    end
    if (setw) m_wel = 1;
    if (clrw) m_wel = 0;
    if (go) m_left = dlen;
    if (sr) begin m_pend = 1; m_plock = d[7]; m_plvl = d[3:2]; end
    @(negedge clk);
    check(op_accept == e_acc, rq, "accept", op_accept, e_acc);
    check(op_reject == e_rej, rq, "reject", op_reject, e_rej);
    check(status == model_status(), "R5", "status", status, model_status());
    check(status[6:4] == 3'b000, "R2", "unused bits", status[6:4], 0);
  endtask

  task automatic idle_until_free();
    while (m_left != 0) cyc(6'b0, '0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status == 8'h00, "R1", "reset status", status, 0);
    check(!op_accept && !op_reject, "R1", "reset answers", {op_accept, op_reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1", "status after release", status, 0);

    cyc(6'b000001, '0, 0, 1);            // R3 wren
    check(status[1] == 1'b1, "R3", "WEL set", status[1], 1);
    cyc(6'b000010, '0, 0, 1);            // R3 wrdi
    check(status[1] == 1'b0, "R3", "WEL clear", status[1], 0);
    cyc(6'b001000, '0, 0, 1);            // R4 pp without WEL
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b001000, 16'h0010, 0, 1);      // R5 pp accepted
    cyc(6'b000001, '0, 0, 1);            // R10 wren during busy
    cyc(6'b000010, '0, 0, 1);            // R10 wrdi during busy
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b000100, '0, 8'h84, 1);        // R6 lock=1, level 01
    check(status[3:2] == 2'b00, "R6", "level staged only", status[3:2], 0);
    idle_until_free();
    check(status[3:2] == 2'b01 && status[7], "R6", "new level", status, 8'h84);
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b001000, 16'hC000, 0, 1);      // R9 top quarter locked
    cyc(6'b010000, 16'hBFFF, 0, 1);      // R9 just below, accepted
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b100000, '0, 0, 1);            // R8 level nonzero
    cyc(6'b000100, '0, 8'h00, 0);        // R7 pin low with lock
    check(status[1] == 1'b1, "R4", "WEL kept after reject", status[1], 1);
    cyc(6'b000100, '0, 8'h08, 1);        // R7 pin high, level 10
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b001000, 16'h8000, 0, 1);      // R9 upper half
    cyc(6'b010000, 16'h7FFF, 0, 1);
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b000100, '0, 8'h0C, 1);        // level 11
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b010000, 16'h0000, 0, 1);      // R9 whole array
    cyc(6'b000100, '0, 8'h00, 1);
    idle_until_free();
    cyc(6'b000001, '0, 0, 1);
    cyc(6'b001001, '0, 0, 1);            // R11 two strobes
    cyc(6'b100000, '0, 0, 1);            // R8 level 00, accepted
    idle_until_free();

    // constrained random phase, fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] c;
      int pick;
      pick = $urandom_range(0, 15);
      if (pick < 5) c = 6'b0;
      else if (pick < 8) c = 6'b000001;
      else if (pick == 15) c = 6'(1 << $urandom_range(0, 5)) | 6'(1 << $urandom_range(0, 5));
      else c = 6'(1 << $urandom_range(1, 5));
      cyc(c, ADDR_W'($urandom), 8'($urandom), ($urandom_range(0, 3) != 0));
    end
    idle_until_free();
    summary();
  end
endmodule